// File: doc/BRIEF.md
# Battery-Adaptive Stepping Motor Driver

This block drives the two coils of a watch stepping motor from a 32768 Hz time base. Once per motor cycle it sends a single drive pulse across the pair of motor terminals. Each new pulse has the opposite polarity to the one before, so the rotor keeps stepping the same way. The cycle length and the pulse width are parameters counted in clock cycles. By default the pulse lasts 256 cycles (about 7.8 ms) and the cycle lasts 32768 cycles (1 s).

Two comparator flags describe the state of the battery. The block samples them on a fixed schedule and turns them into a battery mode:

- In lithium mode every pulse is chopped: six drive cycles, then two cycles with both terminals low, repeated.
- In silver-oxide mode pulses are solid.
- In end-of-life mode pulses are solid and come in bursts of four, one burst every fourth motor cycle. The irregular stepping tells the wearer that the battery is failing.

A tri-state request takes both terminals off the motor. Timing and polarity keep running while the terminals are released.

All pins are plain control and status signals. No data streams through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `watch_motor_drv`

## Requirements
- R1: The battery mode register changes only at sample instants. The first sample instant is rising edge number FIRST_CMP after reset release, 983 by default (about 30 ms). Further sample instants follow every CMP_PERIOD edges, 60 s by default. The flags are sampled at that edge.
- R2: Mode encoding on `batt_mode`: 2'b00 is silver-oxide, 2'b01 is lithium, 2'b10 is end-of-life. End-of-life is chosen when `eol_low` is 1, whatever `lith_ok` is. Otherwise lithium is chosen when `lith_ok` is 1, and silver-oxide when both flags are 0. Reset gives silver-oxide.
- R3: In lithium mode a pulse of PULSE_W cycles is chopped with period 8. Each period starts with 6 driven cycles, followed by 2 cycles with both terminals low.
- R4: In silver-oxide mode each motor cycle opens with one solid pulse of PULSE_W driven cycles, and nothing else is driven in that cycle.
- R5: In end-of-life mode pulses are not chopped. A burst of BURST_N pulses, each PULSE_W cycles long and separated by PULSE_W low cycles, starts at the opening of every BURST_EVERY-th motor cycle. The first burst cycle is motor cycle 0. The other motor cycles carry no pulse.
- R6: A motor cycle uses the mode held in the register during its last clock before the cycle begins. Motor cycle 0, which starts at the first edge after reset, uses silver-oxide.
- R7: The first pulse after reset is positive: `drv_a`=1 and `drv_b`=0. Every later pulse, including each pulse inside a burst, has the opposite polarity to the previous pulse.
- R8: One cycle after `hiz_req` is 1, both output enables are 0 and both drive outputs are 0. Cycle timing and polarity keep advancing during that time.
- R9: Outside driven cycles both drive outputs are 0, and the enables are 1 unless a tri-state request is pending. The drive outputs appear one edge after the internal schedule state. Reset gives 0 on both drive outputs and 1 on both enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz time base |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| lith_ok | input | 1 | Comparator flag: supply at or above the lithium level |
| eol_low | input | 1 | Comparator flag: supply at or below the end-of-life level |
| hiz_req | input | 1 | Request to release both motor terminals |
| drv_a | output | 1 | Motor terminal A drive level |
| drv_b | output | 1 | Motor terminal B drive level |
| drv_a_oe | output | 1 | Output enable for terminal A |
| drv_b_oe | output | 1 | Output enable for terminal B |
| batt_mode | output | 2 | Current battery mode (encoding in R2) |

## Verification
The drive outputs and enables reflect the schedule state and the `hiz_req` value one rising edge later. The mode output changes at the sample edge itself. The bench drives inputs at the falling edge and computes from the requirements what the next rising edge must produce. At the following falling edge it compares the drive outputs, the enables and the mode against that prediction. The reference model advances one state per clock. It derives pulse position, burst slot and chop phase from the cycle count by division, and it keeps its own record of the latched mode and the polarity.

// File: rtl/wmd_pkg.sv
package wmd_pkg;

  typedef enum logic [1:0] {
    MODE_SILVER = 2'b00,
    MODE_LITH   = 2'b01,
    MODE_EOL    = 2'b10
  } batt_mode_e;

  // End-of-life has priority over the lithium flag.
  function automatic batt_mode_e decode_level(input logic lith, input logic eol);
    if (eol)       return MODE_EOL;
    else if (lith) return MODE_LITH;
    else           return MODE_SILVER;
  endfunction

endpackage

// File: rtl/wmd_level_sampler.sv
module wmd_level_sampler
  import wmd_pkg::*;
#(
  parameter int FIRST_CMP  = 983,
  parameter int CMP_PERIOD = 1966080
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lith_i,
  input  logic       eol_i,
  output batt_mode_e mode_o
);

  localparam int TMAX = (FIRST_CMP > CMP_PERIOD) ? FIRST_CMP : CMP_PERIOD;
  localparam int TW   = $clog2(TMAX + 1);

  logic [TW-1:0] tmr_q;
  batt_mode_e    mode_q;

  // Down-counter to the next sample edge; the first interval is the
  // short post-reset delay, every later one is the long period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= TW'(FIRST_CMP - 1);
      mode_q <= MODE_SILVER;
    end else if (tmr_q == '0) begin
      tmr_q  <= TW'(CMP_PERIOD - 1);
      mode_q <= decode_level(lith_i, eol_i);
    end else begin
      tmr_q  <= tmr_q - 1'b1;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/wmd_step_sched.sv
module wmd_step_sched
  import wmd_pkg::*;
#(
  parameter int PULSE_W     = 256,
  parameter int CYCLE_T     = 32768,
  parameter int BURST_N     = 4,
  parameter int BURST_EVERY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  batt_mode_e mode_i,
  output logic       active_o,
  output logic       pulse_last_o,
  output batt_mode_e slot_mode_o
);

  localparam int CW  = $clog2(CYCLE_T);
  localparam int PHW = $clog2(2 * PULSE_W);
  localparam int BIW = $clog2(BURST_N + 1);
  localparam int SW  = (BURST_EVERY > 1) ? $clog2(BURST_EVERY) : 1;

  logic [CW-1:0]  cyc_q;   // position in the motor cycle
  logic [SW-1:0]  sec_q;   // motor cycle index modulo BURST_EVERY
  logic [PHW-1:0] ph_q;    // position in a pulse+gap slot
  logic [BIW-1:0] bi_q;    // slot index inside the cycle, saturating
  batt_mode_e     slot_mode_q;

  logic cyc_wrap, ph_wrap, ph_in_pulse, burst_cycle, burst_left;

  assign cyc_wrap    = (cyc_q == CW'(CYCLE_T - 1));
  assign ph_wrap     = (ph_q == PHW'(2 * PULSE_W - 1));
  assign ph_in_pulse = (int'(ph_q) < PULSE_W);
  assign burst_cycle = (sec_q == '0);
  assign burst_left  = (int'(bi_q) < BURST_N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q       <= '0;
      sec_q       <= '0;
      ph_q        <= '0;
      bi_q        <= '0;
      slot_mode_q <= MODE_SILVER;
    end else if (cyc_wrap) begin
      cyc_q       <= '0;
      ph_q        <= '0;
      bi_q        <= '0;
      slot_mode_q <= mode_i;
      sec_q       <= (sec_q == SW'(BURST_EVERY - 1)) ? '0 : sec_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      ph_q  <= ph_wrap ? '0 : ph_q + 1'b1;
      if (ph_wrap && burst_left) bi_q <= bi_q + 1'b1;
    end
  end

  always_comb begin
    if (slot_mode_q == MODE_EOL)
      active_o = burst_cycle && burst_left && ph_in_pulse;
    else
      active_o = (bi_q == '0) && ph_in_pulse;
  end

  assign pulse_last_o = active_o && (ph_q == PHW'(PULSE_W - 1));
  assign slot_mode_o  = slot_mode_q;

endmodule

// File: rtl/wmd_chop_drive.sv
module wmd_chop_drive
  import wmd_pkg::*;
#(
  parameter int CHOP_PERIOD = 8,
  parameter int CHOP_ON     = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active_i,
  input  logic       pulse_last_i,
  input  batt_mode_e slot_mode_i,
  input  logic       hiz_i,
  output logic       drv_a_o,
  output logic       drv_b_o,
  output logic       drv_a_oe_o,
  output logic       drv_b_oe_o
);

  localparam int CCW = (CHOP_PERIOD > 1) ? $clog2(CHOP_PERIOD) : 1;

  logic chop_on;

  generate
    if (CHOP_PERIOD > 1) begin : g_chop
      logic [CCW-1:0] cc_q;
      // Phase restarts at every pulse because it is held at zero between pulses.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             cc_q <= '0;
        else if (!active_i)                     cc_q <= '0;
        else if (cc_q == CCW'(CHOP_PERIOD - 1)) cc_q <= '0;
        else                                    cc_q <= cc_q + 1'b1;
      end
      assign chop_on = (int'(cc_q) < CHOP_ON);
    end else begin : g_solid
      assign chop_on = 1'b1;
    end
  endgenerate

  logic drive, pol_q;

  assign drive = active_i && ((slot_mode_i != MODE_LITH) || chop_on);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q      <= 1'b1;
      drv_a_o    <= 1'b0;
      drv_b_o    <= 1'b0;
      drv_a_oe_o <= 1'b1;
      drv_b_oe_o <= 1'b1;
    end else begin
      drv_a_o    <= drive &&  pol_q && !hiz_i;
      drv_b_o    <= drive && !pol_q && !hiz_i;
      drv_a_oe_o <= !hiz_i;
      drv_b_oe_o <= !hiz_i;
      if (pulse_last_i) pol_q <= !pol_q;
    end
  end

endmodule

// File: rtl/watch_motor_drv.sv
module watch_motor_drv
  import wmd_pkg::*;
#(
  parameter int PULSE_W     = 256,
  parameter int CYCLE_T     = 32768,
  parameter int FIRST_CMP   = 983,
  parameter int CMP_PERIOD  = 1966080,
  parameter int CHOP_PERIOD = 8,
  parameter int CHOP_ON     = 6,
  parameter int BURST_N     = 4,
  parameter int BURST_EVERY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lith_ok,
  input  logic       eol_low,
  input  logic       hiz_req,
  output logic       drv_a,
  output logic       drv_b,
  output logic       drv_a_oe,
  output logic       drv_b_oe,
  output logic [1:0] batt_mode
);

  batt_mode_e mode_w, slot_mode_w;
  logic       active_w, pulse_last_w;

  wmd_level_sampler #(
    .FIRST_CMP (FIRST_CMP),
    .CMP_PERIOD(CMP_PERIOD)
  ) u_sampler (
    .clk   (clk),
    .rst_n (rst_n),
    .lith_i(lith_ok),
    .eol_i (eol_low),
    .mode_o(mode_w)
  );

  wmd_step_sched #(
    .PULSE_W    (PULSE_W),
    .CYCLE_T    (CYCLE_T),
    .BURST_N    (BURST_N),
    .BURST_EVERY(BURST_EVERY)
  ) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_w),
    .active_o    (active_w),
    .pulse_last_o(pulse_last_w),
    .slot_mode_o (slot_mode_w)
  );

  wmd_chop_drive #(
    .CHOP_PERIOD(CHOP_PERIOD),
    .CHOP_ON    (CHOP_ON)
  ) u_drive (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (active_w),
    .pulse_last_i(pulse_last_w),
    .slot_mode_i (slot_mode_w),
    .hiz_i       (hiz_req),
    .drv_a_o     (drv_a),
    .drv_b_o     (drv_b),
    .drv_a_oe_o  (drv_a_oe),
    .drv_b_oe_o  (drv_b_oe)
  );

  assign batt_mode = mode_w;

endmodule

// File: rtl/wmd_checker.sv
module wmd_checker #(
  parameter int PULSE_W    = 256,
  parameter int FIRST_CMP  = 983,
  parameter int CMP_PERIOD = 1966080
) (
  input logic       clk,
  input logic       rst_n,
  input logic       hiz_req,
  input logic       drv_a,
  input logic       drv_b,
  input logic       drv_a_oe,
  input logic       drv_b_oe,
  input logic [1:0] batt_mode
);

  localparam int TMAX = (FIRST_CMP > CMP_PERIOD) ? FIRST_CMP : CMP_PERIOD;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(PULSE_W + 2);

  logic [TW-1:0] tmr_q;
  logic [RW-1:0] run_q;

  // Independent schedule of sample edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             tmr_q <= TW'(FIRST_CMP - 1);
    else if (tmr_q == '0)   tmr_q <= TW'(CMP_PERIOD - 1);
    else                    tmr_q <= tmr_q - 1'b1;
  end

  // Length of the current run of driven cycles, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          run_q <= '0;
    else if (!(drv_a || drv_b))          run_q <= '0;
    else if (int'(run_q) <= PULSE_W)     run_q <= run_q + 1'b1;
  end

  a_r1_mode_only_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q != '0) |=> $stable(batt_mode));

  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    batt_mode != 2'b11);

  a_r4_pulse_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_a || drv_b) |-> (int'(run_q) < PULSE_W));

  a_r8_hiz_release: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_req |=> (!drv_a_oe && !drv_b_oe && !drv_a && !drv_b));

  a_r9_enable_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !hiz_req |=> (drv_a_oe && drv_b_oe));

endmodule

bind watch_motor_drv wmd_checker #(
  .PULSE_W   (PULSE_W),
  .FIRST_CMP (FIRST_CMP),
  .CMP_PERIOD(CMP_PERIOD)
) i_wmd_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .hiz_req  (hiz_req),
  .drv_a    (drv_a),
  .drv_b    (drv_b),
  .drv_a_oe (drv_a_oe),
  .drv_b_oe (drv_b_oe),
  .batt_mode(batt_mode)
);

// File: tb/test_watch_motor_drv.sv
`timescale 1ns/1ps
module test_watch_motor_drv;

  localparam int PW    = 8;
  localparam int CT    = 64;
  localparam int FIRST = 30;
  localparam int CP    = 500;
  localparam int CHP   = 8;
  localparam int CHON  = 6;
  localparam int BN    = 4;
  localparam int BE    = 4;
  localparam int NCYC  = 20000;

  localparam int M_SIL = 0, M_LITH = 1, M_EOL = 2;

  logic clk = 1'b0;
  logic rst_n, lith_ok, eol_low, hiz_req;
  logic drv_a, drv_b, drv_a_oe, drv_b_oe;
  logic [1:0] batt_mode;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  watch_motor_drv #(
    .PULSE_W(PW), .CYCLE_T(CT), .FIRST_CMP(FIRST), .CMP_PERIOD(CP),
    .CHOP_PERIOD(CHP), .CHOP_ON(CHON), .BURST_N(BN), .BURST_EVERY(BE)
  ) i_watch_motor_drv (
    .clk(clk), .rst_n(rst_n), .lith_ok(lith_ok), .eol_low(eol_low),
    .hiz_req(hiz_req), .drv_a(drv_a), .drv_b(drv_b), .drv_a_oe(drv_a_oe),
    .drv_b_oe(drv_b_oe), .batt_mode(batt_mode)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int f_decode(input bit lith, input bit eol);
    if (eol) return M_EOL;
    if (lith) return M_LITH;
    return M_SIL;
  endfunction

  function automatic bit f_tick(input int t);
    if (t == FIRST - 1) return 1'b1;
    if (t > FIRST - 1 && ((t - (FIRST - 1)) % CP) == 0) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit f_active(input int t, input int mlat);
    int c, sec, ph, bi;
    c   = t % CT;
    sec = (t / CT) % BE;
    ph  = c % (2 * PW);
    bi  = c / (2 * PW);
    if (mlat == M_EOL) return (sec == 0) && (bi < BN) && (ph < PW);
    return c < PW;
  endfunction

  function automatic bit f_drive(input int t, input int mlat);
    int ph;
    ph = (t % CT) % (2 * PW);
    return f_active(t, mlat) && ((mlat != M_LITH) || ((ph % CHP) < CHON));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int  b_mode, b_mlat, e_mlat, e_mode, e_a, e_b, e_oe, e_drv;
    bit  b_pol, e_hiz, e_tick, act;
    int  t, c, ph;
    string tag;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; lith_ok = 1'b0; eol_low = 1'b0; hiz_req = 1'b0;
    repeat (3) @(negedge clk);
    // Reset state
    chk("R9", "reset drv_a", int'(drv_a), 0);
    chk("R9", "reset drv_b", int'(drv_b), 0);
    chk("R9", "reset enables", int'({drv_a_oe, drv_b_oe}), 3);
    chk("R2", "reset mode", int'(batt_mode), M_SIL);

    b_mode = M_SIL; b_mlat = M_SIL; b_pol = 1'b1;
    e_mlat = M_SIL; e_mode = M_SIL; e_a = 0; e_b = 0; e_oe = 1; e_drv = 0;
    e_hiz = 0; e_tick = 0;
    rst_n = 1'b1;
    for (t = 0; t < NCYC; t++) begin
      if (t > 0) begin
        // Outputs now reflect the state t-1 prediction.
        if (t == 1) chk("R7", "first pulse positive", int'({drv_a, drv_b}), 2);
        if (e_hiz) tag = "R8";
        else if (!e_drv) tag = "R9";
        else if (e_mlat != b_mode) tag = "R6";
        else if (e_mlat == M_LITH) tag = "R3";
        else if (e_mlat == M_EOL) tag = "R5";
        else tag = "R4";
        chk(tag, "driven", int'(drv_a | drv_b), (e_a | e_b));
        if (e_drv && !e_hiz) chk("R7", "polarity drv_a", int'(drv_a), e_a);
        chk(e_hiz ? "R8" : "R9", "enables", int'({drv_a_oe, drv_b_oe}), e_oe ? 3 : 0);
        chk(e_tick ? "R2" : "R1", "mode", int'(batt_mode), e_mode);
      end

      // Stimulus: directed phases, then constrained random.
      if (t < 1500)      begin lith_ok = 1; eol_low = 0; hiz_req = 0; end
      else if (t < 3000) begin lith_ok = 0; eol_low = 1; hiz_req = 0; end
      else if (t < 4500) begin lith_ok = 0; eol_low = 0; hiz_req = 0; end
      else if (t < 5500) begin lith_ok = 1; eol_low = 1; hiz_req = (t >= 5200 && t < 5260); end
      else begin
        if ($urandom_range(0, 299) == 0) begin
          lith_ok = 1'($urandom_range(0, 1));
          eol_low = ($urandom_range(0, 3) == 0);
        end
        if ($urandom_range(0, 399) == 0) hiz_req = !hiz_req;
      end

      // Reference model for state t.
      c   = t % CT;
      ph  = c % (2 * PW);
      act = f_active(t, b_mlat);
      e_drv = int'(f_drive(t, b_mlat));
      e_hiz = hiz_req;
      e_a  = (e_drv != 0 &&  b_pol && !hiz_req) ? 1 : 0;
      e_b  = (e_drv != 0 && !b_pol && !hiz_req) ? 1 : 0;
      e_oe = hiz_req ? 0 : 1;
      e_mlat = b_mlat;
      if (act && ph == PW - 1) b_pol = !b_pol;
      if (c == CT - 1) b_mlat = b_mode;
      e_tick = f_tick(t);
      if (e_tick) b_mode = f_decode(lith_ok, eol_low);
      e_mode = b_mode;
      @(negedge clk);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule